// File: doc/BRIEF.md
# Framed PCM Serial Port

This block is the device-side serial port of a voice codec. All of its framing logic runs on the falling edge of a master bit clock. A frame-sync pulse marks the start of each frame, and a frame is nominally 256 master-clock cycles long. At each frame start the block takes one transmit sample from a parallel input and shifts it out MSB first on a serial output that it can tri-state. In the same slot it deserialises one receive word from a serial input. A mode input chooses the word format. With the input low, words are 13-bit two's-complement linear, and each receive word carries three more volume bits after the sample. With the input high, words are 8-bit companded.

Control is a four-state machine:
- `ST_UNSYNCED` is the state after reset. It holds until the first frame sync.
- `ST_XFER` shifts the transmit word and receives the sample bits.
- `ST_RXTAIL` collects the three trailing volume bits in linear mode only.
- `ST_GAP` waits for the next frame.

The transitions are as follows:
- A frame-sync rising edge moves any state to `ST_XFER` and restarts the frame.
- `ST_XFER` moves to `ST_RXTAIL` after the last linear sample bit.
- `ST_XFER` moves to `ST_GAP` after the last companded bit.
- `ST_RXTAIL` moves to `ST_GAP` after the third volume bit.

A second, independent slow clock runs a watchdog. The watchdog declares power-down once the master clock has stopped toggling. Power-down is never declared while a transmit word is in flight.

Top module: `pcm_serial_port`

## Requirements
- R1: On the falling master-clock edge where frame sync is first sampled high after being low, the block starts a frame. From that edge `tx_oe` is high and `tx_data` carries the first (most significant) bit.
- R2: With `companded_sel` low at the frame start, the block shifts out 13 bits, `tx_sample[12]` first, one bit per master-clock cycle. `tx_oe` falls at the edge that ends the 13th bit.
- R3: With `companded_sel` high at the frame start, the block shifts out 8 bits, `tx_sample[7]` first. `tx_oe` falls after the 8th bit, and `tx_sample[12:8]` has no effect.
- R4: In linear mode, the block samples `rx_in` on the 16 falling edges that follow the frame-start edge. The first 13 bits form `rx_sample[12:0]`, MSB first. The last three bits form `rx_vol`, with the 14th bit in `rx_vol[2]`. `rx_valid` is high for exactly one cycle, set at the 16th edge.
- R5: In companded mode, the block samples 8 bits into `rx_sample[7:0]`, MSB first. `rx_sample[12:8]` is 0, `rx_vol` is the unity-gain code 3'b001, and `rx_valid` pulses once, set at the 8th edge.
- R6: `companded_sel` is sampled only at the frame start. A change to it later in the frame does not alter the word length of that frame.
- R7: `tx_taken` pulses for one cycle after the frame-start edge, when the sample is captured. Changes to `tx_sample` after that edge do not affect the word being sent.
- R8: A frame sync that arrives fewer than 256 cycles after the previous one restarts the frame and pulses `frame_err` for one cycle. A sync exactly 256 cycles after the previous one does not flag an error. A late sync does not flag an error, and neither does the first sync after reset.
- R9: If the master clock stops while no transmit word is in flight, `pwr_down` rises within a bounded number of slow-clock cycles and `tx_oe` is low. `pwr_down` clears after the master clock resumes.
- R10: If the master clock stops while a transmit word is in flight, `pwr_down` stays low.
- R11: During and after reset, and before the first frame sync, `tx_oe`, `rx_valid`, `frame_err`, `tx_taken` and `pwr_down` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master bit clock; the block uses its falling edge |
| wd_clk | input | 1 | Independent slow clock for the clock-loss watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, one per 256 master clocks |
| companded_sel | input | 1 | 0 selects 13-bit linear words, 1 selects 8-bit companded words |
| tx_sample | input | 13 | Parallel transmit sample; companded mode uses bits 7:0 |
| tx_taken | output | 1 | One-cycle strobe: transmit sample captured |
| tx_data | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Output enable for tx_data; low means high impedance |
| rx_in | input | 1 | Serial receive bit |
| rx_sample | output | 13 | Received sample |
| rx_vol | output | 3 | Received volume code (3'b001 in companded mode) |
| rx_valid | output | 1 | One-cycle strobe: rx_sample and rx_vol updated |
| frame_err | output | 1 | One-cycle pulse on an early frame sync |
| pwr_down | output | 1 | High while the master clock is judged lost |

## Verification
The bench runs linear frames with extreme samples: full-scale positive, full-scale negative, all ones, zero with a maximal volume field, and alternating bit patterns. These frames separate an MSB-first order from a reversed order and expose a swap between the sample and volume fields. Companded frames carry non-zero upper transmit bits, which shows whether alignment and truncation are right. Other frames flip the mode pin or change the transmit sample mid-frame, to show that both are latched at the frame start. Early, exact and late sync spacing separate a genuine framing error from a false one. The master clock is stopped once in the gap between frames and once inside a word, which distinguishes deferred power-down from immediate power-down.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [1:0] {
        ST_UNSYNCED = 2'd0,
        ST_XFER     = 2'd1,
        ST_RXTAIL   = 2'd2,
        ST_GAP      = 2'd3
    } pcm_state_t;
endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
    import pcm_port_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    parameter int LIN_BITS  = 13,
    parameter int CMP_BITS  = 8,
    parameter int VOL_BITS  = 3
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic fsync,
    input  logic companded_sel,
    output logic load_word,
    output logic shift_tx,
    output logic cap_rx,
    output logic rx_last,
    output logic word_lin,
    output logic tx_busy,
    output logic frame_err
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LIN_LAST  = CNT_W'(LIN_BITS - 1);
    localparam logic [CNT_W-1:0] CMP_LAST  = CNT_W'(CMP_BITS - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(LIN_BITS + VOL_BITS - 1);

    pcm_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             fs_q;
    logic             locked;
    logic             cmp_q;
    logic             sync_rise;
    logic [CNT_W-1:0] word_last;

    assign sync_rise = fsync & ~fs_q;
    assign word_last = cmp_q ? CMP_LAST : LIN_LAST;

    // state register
    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNSYNCED;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (sync_rise) begin
            state_nxt = ST_XFER;
        end else begin
            unique case (state)
                ST_UNSYNCED: state_nxt = ST_UNSYNCED;
                ST_XFER:     if (cnt == word_last)
                                 state_nxt = cmp_q ? ST_GAP : ST_RXTAIL;
                ST_RXTAIL:   if (cnt == TAIL_LAST) state_nxt = ST_GAP;
                ST_GAP:      state_nxt = ST_GAP;
                default:     state_nxt = ST_UNSYNCED;
            endcase
        end
    end

    // output decode
    always_comb begin
        load_word = sync_rise;
        shift_tx  = !sync_rise && (state == ST_XFER);
        cap_rx    = !sync_rise && ((state == ST_XFER) || (state == ST_RXTAIL));
        rx_last   = cap_rx &&
                    (((state == ST_XFER) && cmp_q && (cnt == CMP_LAST)) ||
                     ((state == ST_RXTAIL) && (cnt == TAIL_LAST)));
        tx_busy   = (state == ST_XFER);
        word_lin  = !cmp_q;
    end

    // frame position, sync edge detection, mode latch, framing error
    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            fs_q      <= 1'b0;
            locked    <= 1'b0;
            cmp_q     <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            fs_q      <= fsync;
            frame_err <= sync_rise && locked && (cnt != CNT_MAX);
            if (sync_rise) begin
                cnt    <= '0;
                locked <= 1'b1;
                cmp_q  <= companded_sel;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
    parameter int LIN_BITS = 13,
    parameter int CMP_BITS = 8
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic                companded_sel,
    input  logic [LIN_BITS-1:0] sample,
    output logic                tx_data,
    output logic                tx_taken
);
    localparam int PAD = LIN_BITS - CMP_BITS;

    logic [LIN_BITS-1:0] sh;
    logic [LIN_BITS-1:0] cmp_aligned;

    generate
        if (PAD > 0) begin : g_pad
            assign cmp_aligned = {sample[CMP_BITS-1:0], {PAD{1'b0}}};
        end else begin : g_nopad
            assign cmp_aligned = sample;
        end
    endgenerate

    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            tx_taken <= 1'b0;
        end else begin
            tx_taken <= load;
            if (load)       sh <= companded_sel ? cmp_aligned : sample;
            else if (shift) sh <= {sh[LIN_BITS-2:0], 1'b0};
        end
    end

    assign tx_data = sh[LIN_BITS-1];
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int LIN_BITS  = 13,
    parameter int CMP_BITS  = 8,
    parameter int VOL_BITS  = 3,
    parameter int VOL_UNITY = 1
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic                last,
    input  logic                word_lin,
    input  logic                rx_in,
    output logic [LIN_BITS-1:0] rx_sample,
    output logic [VOL_BITS-1:0] rx_vol,
    output logic                rx_valid
);
    localparam int RX_W = LIN_BITS + VOL_BITS;
    localparam int PAD  = LIN_BITS - CMP_BITS;

    logic [RX_W-1:0]     sh;
    logic [RX_W-1:0]     nxt;
    logic [LIN_BITS-1:0] cmp_word;

    assign nxt = {sh[RX_W-2:0], rx_in};

    generate
        if (PAD > 0) begin : g_pad
            assign cmp_word = {{PAD{1'b0}}, nxt[CMP_BITS-1:0]};
        end else begin : g_nopad
            assign cmp_word = nxt[LIN_BITS-1:0];
        end
    endgenerate

    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            rx_sample <= '0;
            rx_vol    <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= last;
            if (cap) sh <= nxt;
            if (last) begin
                if (word_lin) begin
                    rx_sample <= nxt[RX_W-1:VOL_BITS];
                    rx_vol    <= nxt[VOL_BITS-1:0];
                end else begin
                    rx_sample <= cmp_word;
                    rx_vol    <= VOL_BITS'(VOL_UNITY);
                end
            end
        end
    end
endmodule

// File: rtl/pcm_clk_watchdog.sv
module pcm_clk_watchdog #(
    parameter int HB_BITS     = 4,
    parameter int WD_LIMIT    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic wd_clk,
    input  logic rst_n,
    input  logic tx_busy,
    output logic pwr_down
);
    localparam int WD_W = $clog2(WD_LIMIT + 1);
    localparam logic [WD_W-1:0] WD_MAX = WD_W'(WD_LIMIT);

    logic [HB_BITS-1:0]     hb_cnt;
    logic [SYNC_STAGES-1:0] hb_pipe;
    logic [SYNC_STAGES-1:0] busy_pipe;
    logic                   hb_prev;
    logic                   activity;
    logic [WD_W-1:0]        wd_cnt;

    // heartbeat in the master-clock domain
    always_ff @(negedge mclk or negedge rst_n) begin
        if (!rst_n) hb_cnt <= '0;
        else        hb_cnt <= hb_cnt + 1'b1;
    end

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_pipe   <= '0;
            busy_pipe <= '0;
            hb_prev   <= 1'b0;
        end else begin
            hb_pipe   <= {hb_pipe[SYNC_STAGES-2:0], hb_cnt[HB_BITS-1]};
            busy_pipe <= {busy_pipe[SYNC_STAGES-2:0], tx_busy};
            hb_prev   <= hb_pipe[SYNC_STAGES-1];
        end
    end

    assign activity = hb_pipe[SYNC_STAGES-1] ^ hb_prev;

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_cnt   <= '0;
            pwr_down <= 1'b0;
        end else begin
            if (activity)              wd_cnt <= '0;
            else if (wd_cnt != WD_MAX) wd_cnt <= wd_cnt + 1'b1;
            pwr_down <= (wd_cnt == WD_MAX) && !busy_pipe[SYNC_STAGES-1];
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int FRAME_LEN   = 256,
    parameter int LIN_BITS    = 13,
    parameter int CMP_BITS    = 8,
    parameter int VOL_BITS    = 3,
    parameter int VOL_UNITY   = 1,
    parameter int HB_BITS     = 4,
    parameter int WD_LIMIT    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                mclk,
    input  logic                wd_clk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                companded_sel,
    input  logic [LIN_BITS-1:0] tx_sample,
    output logic                tx_taken,
    output logic                tx_data,
    output logic                tx_oe,
    input  logic                rx_in,
    output logic [LIN_BITS-1:0] rx_sample,
    output logic [VOL_BITS-1:0] rx_vol,
    output logic                rx_valid,
    output logic                frame_err,
    output logic                pwr_down
);
    logic load_word, shift_tx, cap_rx, rx_last, word_lin, tx_busy;

    pcm_frame_ctrl #(
        .FRAME_LEN(FRAME_LEN), .LIN_BITS(LIN_BITS),
        .CMP_BITS(CMP_BITS), .VOL_BITS(VOL_BITS)
    ) ctrl_i (
        .mclk(mclk), .rst_n(rst_n), .fsync(fsync),
        .companded_sel(companded_sel),
        .load_word(load_word), .shift_tx(shift_tx), .cap_rx(cap_rx),
        .rx_last(rx_last), .word_lin(word_lin), .tx_busy(tx_busy),
        .frame_err(frame_err)
    );

    pcm_tx_shifter #(.LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS)) tx_i (
        .mclk(mclk), .rst_n(rst_n), .load(load_word), .shift(shift_tx),
        .companded_sel(companded_sel), .sample(tx_sample),
        .tx_data(tx_data), .tx_taken(tx_taken)
    );

    pcm_rx_deser #(
        .LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS),
        .VOL_BITS(VOL_BITS), .VOL_UNITY(VOL_UNITY)
    ) rx_i (
        .mclk(mclk), .rst_n(rst_n), .cap(cap_rx), .last(rx_last),
        .word_lin(word_lin), .rx_in(rx_in),
        .rx_sample(rx_sample), .rx_vol(rx_vol), .rx_valid(rx_valid)
    );

    pcm_clk_watchdog #(
        .HB_BITS(HB_BITS), .WD_LIMIT(WD_LIMIT), .SYNC_STAGES(SYNC_STAGES)
    ) wd_i (
        .mclk(mclk), .wd_clk(wd_clk), .rst_n(rst_n),
        .tx_busy(tx_busy), .pwr_down(pwr_down)
    );

    assign tx_oe = tx_busy & ~pwr_down;
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic mclk,
    input logic wd_clk,
    input logic rst_n,
    input logic tx_taken,
    input logic tx_oe,
    input logic rx_valid,
    input logic frame_err,
    input logic pwr_down
);
    // R4
    rx_strobe_single_chk: assert property (@(negedge mclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    taken_drives_chk: assert property (@(negedge mclk) disable iff (!rst_n)
        tx_taken |-> (tx_oe || pwr_down));

    // R8
    err_restarts_chk: assert property (@(negedge mclk) disable iff (!rst_n)
        frame_err |-> (tx_oe || pwr_down));

    // R2
    word_end_hiz_chk: assert property (@(negedge mclk) disable iff (!rst_n)
        rx_valid |-> !tx_oe);

    // R10
    pd_deferred_chk: assert property (@(posedge wd_clk) disable iff (!rst_n)
        $rose(pwr_down) |-> !$past(tx_oe));
endmodule

bind pcm_serial_port pcm_serial_port_chk chk_i (
    .mclk(mclk), .wd_clk(wd_clk), .rst_n(rst_n), .tx_taken(tx_taken),
    .tx_oe(tx_oe), .rx_valid(rx_valid), .frame_err(frame_err),
    .pwr_down(pwr_down)
);

// File: tb/pcm_serial_port_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;
    logic        mclk_free = 1'b0;
    logic        mclk_en   = 1'b1;
    logic        mclk;
    logic        wd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        fsync = 1'b0, companded_sel = 1'b0, rx_in = 1'b0;
    logic [12:0] tx_sample = '0;
    logic        tx_taken, tx_data, tx_oe, rx_valid, frame_err, pwr_down;
    logic [12:0] rx_sample;
    logic [2:0]  rx_vol;

    int  n_cmp = 0, n_bad = 0, err_seen = 0;
    bit  cmp_en = 0, done = 0;

    always #2  mclk_free = ~mclk_free;
    always #10 wd_clk    = ~wd_clk;
    assign mclk = mclk_free & mclk_en;

    pcm_serial_port dut_i (
        .mclk(mclk), .wd_clk(wd_clk), .rst_n(rst_n), .fsync(fsync),
        .companded_sel(companded_sel), .tx_sample(tx_sample),
        .tx_taken(tx_taken), .tx_data(tx_data), .tx_oe(tx_oe), .rx_in(rx_in),
        .rx_sample(rx_sample), .rx_vol(rx_vol), .rx_valid(rx_valid),
        .frame_err(frame_err), .pwr_down(pwr_down)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_fs, m_locked, m_active, m_lin;
    int          m_since, m_k;
    logic [12:0] m_txword;
    bit          m_rxq[$];
    bit          e_oe, e_bit, e_valid, e_taken, e_err;
    logic [12:0] e_sample;
    logic [2:0]  e_vol;

    always @(negedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            m_fs = 0; m_locked = 0; m_active = 0; m_lin = 1; m_since = 0; m_k = 0;
            e_oe = 0; e_bit = 0; e_valid = 0; e_taken = 0; e_err = 0;
            e_sample = '0; e_vol = '0; m_rxq.delete();
        end else begin
            bit rise;
            int txlen, rxlen;
            rise = fsync && !m_fs;
            m_fs = fsync;
            e_err = rise && m_locked && (m_since != 255);
            e_taken = rise;
            e_valid = 0;
            if (rise) begin
                m_locked = 1; m_since = 0; m_k = 0; m_active = 1;
                m_lin = !companded_sel;
                m_txword = m_lin ? tx_sample : {5'b0, tx_sample[7:0]};
                m_rxq.delete();
            end else begin
                if (m_since < 255) m_since++;
                if (m_active) begin
                    m_k++;
                    m_rxq.push_back(rx_in);
                    rxlen = m_lin ? 16 : 8;
                    if (m_k == rxlen) begin
                        int s;
                        s = 0;
                        e_valid = 1;
                        m_active = 0;
                        if (m_lin) begin
                            for (int i = 0; i < 13; i++) s = (s << 1) | int'(m_rxq[i]);
                            e_sample = 13'(s);
                            e_vol = {m_rxq[13], m_rxq[14], m_rxq[15]};
                        end else begin
                            for (int i = 0; i < 8; i++) s = (s << 1) | int'(m_rxq[i]);
                            e_sample = 13'(s);
                            e_vol = 3'b001;
                        end
                    end
                end
            end
            txlen = m_lin ? 13 : 8;
            e_oe  = m_active && (m_k < txlen);
            e_bit = e_oe ? m_txword[txlen-1-m_k] : 1'b0;
        end
    end

    always @(posedge mclk) begin
        if (rst_n && cmp_en) begin
            string ttag, rtag;
            ttag = (m_k == 0 && e_oe) ? "R1" : (m_lin ? "R2" : "R3");
            rtag = m_lin ? "R4" : "R5";
            chk(ttag, tx_oe, e_oe && !pwr_down);
            if (e_oe && tx_oe) chk(ttag, tx_data, e_bit);
            chk(rtag, rx_valid, e_valid);
            if (e_valid) begin
                chk(rtag, rx_sample, e_sample);
                chk(rtag, rx_vol, e_vol);
            end
            chk("R7", tx_taken, e_taken);
            chk("R8", frame_err, e_err);
            if (frame_err) err_seen++;
        end
    end

    task automatic stop_clock(input bit expect_pd, input string tag);
        @(negedge mclk);
        #1 mclk_en = 1'b0;
        #800;
        chk(tag, pwr_down, expect_pd);
        if (expect_pd) chk(tag, tx_oe, 1'b0);
        @(negedge mclk_free);
        mclk_en = 1'b1;
    endtask

    // one frame: len cycles, optional mode flip and clock stop points
    task automatic run_frame(input bit cmp, input logic [12:0] smp, input logic [15:0] rxw,
                             input int len, input int flip_at, input int stop_at,
                             output int oe_cnt);
        oe_cnt = 0;
        @(posedge mclk);
        fsync = 1'b1; companded_sel = cmp; tx_sample = smp; rx_in = 1'b0;
        for (int c = 1; c < len; c++) begin
            @(posedge mclk);
            fsync = 1'b0;
            if (tx_oe) oe_cnt++;
            if (c == 1) tx_sample = ~smp;          // R7: late change ignored
            rx_in = (c <= 16) ? rxw[16-c] : 1'b0;
            if (c == flip_at) companded_sel = !cmp; // R6
            if (c == stop_at) stop_clock(stop_at > 20, stop_at > 20 ? "R9" : "R10");
        end
    endtask

    initial begin
        int oe_n;
        repeat (6) @(posedge mclk);
        // R11 reset state
        chk("R11", {tx_oe, rx_valid, frame_err, tx_taken, pwr_down}, 5'b0);
        rst_n = 1'b1;
        repeat (20) @(posedge mclk);
        chk("R11", {tx_oe, rx_valid, frame_err, tx_taken, pwr_down}, 5'b0);
        cmp_en = 1;
        run_frame(0, 13'h0FFF, 16'hA5C3, 256, 0, 0, oe_n);
        chk("R2", oe_n, 13);
        run_frame(0, 13'h1000, 16'h5A3C, 256, 0, 0, oe_n);
        run_frame(0, 13'h1FFF, 16'hFFFF, 256, 0, 0, oe_n);
        run_frame(0, 13'h0000, 16'h0007, 256, 0, 0, oe_n);
        run_frame(0, 13'h0AAA, 16'h8001, 256, 0, 0, oe_n);
        run_frame(1, 13'h1F5A, 16'hC300, 256, 0, 0, oe_n);
        chk("R3", oe_n, 8);
        run_frame(1, 13'h0080, 16'h7F00, 256, 0, 0, oe_n);
        run_frame(1, 13'h1E01, 16'h8100, 256, 0, 0, oe_n);
        run_frame(0, 13'h1234, 16'h6E51, 256, 5, 0, oe_n);
        chk("R6", oe_n, 13);
        run_frame(1, 13'h00C5, 16'h3C00, 256, 3, 0, oe_n);
        chk("R6", oe_n, 8);
        chk("R8", err_seen, 0);
        run_frame(0, 13'h0555, 16'h1234, 100, 0, 0, oe_n);
        run_frame(0, 13'h1555, 16'h4321, 300, 0, 0, oe_n);
        run_frame(0, 13'h0F0F, 16'hF0F0, 256, 0, 0, oe_n);
        chk("R8", err_seen, 1);
        run_frame(1, 13'h005A, 16'hA500, 256, 0, 200, oe_n);
        chk("R9", pwr_down, 1'b0);
        run_frame(0, 13'h0C3A, 16'h9E6B, 256, 0, 6, oe_n);
        chk("R10", oe_n, 13);
        run_frame(0, 13'h1111, 16'h2222, 256, 0, 0, oe_n);
        chk("R8", err_seen, 1);
        repeat (20) @(posedge mclk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule